// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a memory-mapped interval timer with a parameterised number of independent 32-bit down-counters, reached through an APB3 slave port with no wait states. Each channel holds a reload value, a live count and a three-bit control word. Software arms a channel by writing its reload value and then setting the enable bit. From then on the count steps down by one on every clock. At zero the channel wraps: to all ones in free-running mode, or to its stored reload value in periodic mode.

Every time a channel reaches zero it sets a raw pending flag. A per-channel mask bit hides that flag from the channel's interrupt output without stopping it from being recorded. A pending flag is cleared by reading that channel's end-of-interrupt register, or by reading a shared register that clears every channel at once. Shared read-only registers report the masked and raw pending flags of all channels and a fixed version word.

Top module: `apb_dcount_timer`

## Requirements
- R1: After synchronous reset every reload value, count, control word and pending flag reads as zero, and all `irq` outputs are low.
- R2: Channel n occupies offsets 0x14*n + {0x00 reload, 0x04 current count, 0x08 control, 0x0C end-of-interrupt, 0x10 status}. Control bit 0 is enable, bit 1 selects periodic mode (0 = free-running), and bit 2 is the mask. Reload and control read back as written, and control bits above bit 2 read as zero.
- R3: A write that changes the enable bit from 0 to 1 loads the count from the reload register. The loaded value is visible at the next clock edge.
- R4: An enabled channel decrements its count by one on every clock. A disabled channel holds its count.
- R5: In free-running mode an enabled count of zero becomes 0xFFFFFFFF on the next clock.
- R6: In periodic mode an enabled count of zero becomes the reload value on the next clock.
- R7: Writing the reload register of an enabled channel does not alter the running count. The new value is used at the next reload.
- R8: An enabled count of zero sets the channel's raw pending flag, whatever the mask. Shared offset 0xA8 returns raw flags, with bit n for channel n.
- R9: Masked pending equals raw AND NOT mask. `irq[n]`, bit 0 of channel n's status register and bit n of shared offset 0xA0 all show it.
- R10: A read of channel n's end-of-interrupt register returns zero and clears only channel n's pending flag. It has no other effect.
- R11: A read of shared offset 0xA4 returns zero and clears the pending flags of all channels.
- R12: Offset 0xAC returns the VERSION parameter. Reads of unmapped offsets return zero. `pready` is always 1 and `pslverr` always 0.
- R13: Clearing the enable bit leaves a pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
Assertions inside each channel check the counting rules on every clock:
- the load on an enable edge;
- the single-step decrement;
- both kinds of wrap at zero;
- holding the count while disabled;
- the count staying undisturbed by a reload write;
- raw flags being set at zero, cleared by an end-of-interrupt read, and otherwise held.

Only the bench's scenarios can show that the register decode places each channel at its offset and that the shared registers pack the flags by channel. The same applies to a per-channel clear leaving other channels pending, the mask hiding a flag that stays recorded, and the read-back values of the version word and unmapped offsets.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CH_STRIDE = 'h14;

    localparam logic [4:0] OFF_LOAD = 5'h00;
    localparam logic [4:0] OFF_CUR  = 5'h04;
    localparam logic [4:0] OFF_CTRL = 5'h08;
    localparam logic [4:0] OFF_EOI  = 5'h0C;
    localparam logic [4:0] OFF_STAT = 5'h10;

    localparam int unsigned SH_MASKED = 'hA0;
    localparam int unsigned SH_EOI    = 'hA4;
    localparam int unsigned SH_RAW    = 'hA8;
    localparam int unsigned SH_VER    = 'hAC;

    // bit 2 mask, bit 1 periodic, bit 0 enable
    typedef struct packed {
        logic mask;
        logic periodic;
        logic en;
    } tmr_ctrl_t;

    typedef enum logic [2:0] {
        RG_LOAD, RG_CUR, RG_CTRL, RG_EOI, RG_STAT, RG_NONE
    } chreg_e;

    function automatic tmr_ctrl_t ctrl_from_word(input logic [2:0] w);
        tmr_ctrl_t c;
        c.mask     = w[2];
        c.periodic = w[1];
        c.en       = w[0];
        return c;
    endfunction

    function automatic chreg_e decode_off(input logic [4:0] rel);
        case (rel)
            OFF_LOAD: return RG_LOAD;
            OFF_CUR:  return RG_CUR;
            OFF_CTRL: return RG_CTRL;
            OFF_EOI:  return RG_EOI;
            OFF_STAT: return RG_STAT;
            default:  return RG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_load,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic          eoi_clr,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] count_o,
    output tmr_ctrl_t     ctrl_o,
    output logic          raw_o,
    output logic          irq_o
);

    logic [DW-1:0] load_q, cnt_q;
    tmr_ctrl_t     ctrl_q;
    logic          raw_q;
    logic          start, term;

    assign start = wr_ctrl && wdata[0] && !ctrl_q.en;
    assign term  = ctrl_q.en && !start && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            if (wr_load) load_q <= wdata;
            if (wr_ctrl) ctrl_q <= ctrl_from_word(wdata[2:0]);

            if (start)
                cnt_q <= load_q;
            else if (ctrl_q.en) begin
                if (cnt_q == '0)
                    cnt_q <= ctrl_q.periodic ? load_q : '1;
                else
                    cnt_q <= cnt_q - 1'b1;
            end

            if (term)
                raw_q <= 1'b1;
            else if (eoi_clr)
                raw_q <= 1'b0;
        end
    end

    assign load_o  = load_q;
    assign count_o = cnt_q;
    assign ctrl_o  = ctrl_q;
    assign raw_o   = raw_q;
    assign irq_o   = raw_q & ~ctrl_q.mask;

    assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> cnt_q == $past(load_q));
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && !start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_hold_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !start) |=> $stable(cnt_q));
    assert_wrap_free_R5: assert property (@(posedge clk) disable iff (rst)
        (term && !ctrl_q.periodic) |=> cnt_q == '1);
    assert_wrap_periodic_R6: assert property (@(posedge clk) disable iff (rst)
        (term && ctrl_q.periodic) |=> cnt_q == $past(load_q));
    assert_reload_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_load && ctrl_q.en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    assert_tc_sets_raw_R8: assert property (@(posedge clk) disable iff (rst)
        term |=> raw_q);
    assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (eoi_clr && !term) |=> !raw_q);
    assert_pending_kept_R13: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !eoi_clr) |=> raw_q);

endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [NUM_CH-1:0] wr_load,
    output logic [NUM_CH-1:0] wr_ctrl,
    output logic [NUM_CH-1:0] eoi_rd,
    output logic              all_eoi
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * CH_STRIDE);
        assign wr_load[i] = wr_en && (paddr == BASE + ADDR_W'(OFF_LOAD));
        assign wr_ctrl[i] = wr_en && (paddr == BASE + ADDR_W'(OFF_CTRL));
        assign eoi_rd[i]  = rd_en && (paddr == BASE + ADDR_W'(OFF_EOI));
    end

    assign all_eoi = rd_en && (paddr == ADDR_W'(SH_EOI));

endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          ADDR_W  = 8,
    parameter int          DW      = 32,
    parameter logic [31:0] VERSION = 32'h0001_0203
) (
    input  logic [ADDR_W-1:0]          paddr,
    input  logic [NUM_CH-1:0][DW-1:0]  load_v,
    input  logic [NUM_CH-1:0][DW-1:0]  count_v,
    input  tmr_ctrl_t [NUM_CH-1:0]     ctrl_v,
    input  logic [NUM_CH-1:0]          raw_v,
    input  logic [NUM_CH-1:0]          pend_v,
    output logic [DW-1:0]              rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            logic [ADDR_W-1:0] base;
            base = ADDR_W'(i * CH_STRIDE);
            if (paddr >= base && paddr < base + ADDR_W'(CH_STRIDE)) begin
                case (decode_off(5'(paddr - base)))
                    RG_LOAD: rdata = load_v[i];
                    RG_CUR:  rdata = count_v[i];
                    RG_CTRL: rdata = DW'(ctrl_v[i]);
                    RG_STAT: rdata = DW'(pend_v[i]);
                    default: rdata = '0;
                endcase
            end
        end
        if (paddr == ADDR_W'(SH_MASKED)) rdata = DW'(pend_v);
        if (paddr == ADDR_W'(SH_RAW))    rdata = DW'(raw_v);
        if (paddr == ADDR_W'(SH_VER))    rdata = DW'(VERSION);
    end

endmodule

// File: rtl/apb_dcount_timer.sv
module apb_dcount_timer
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          ADDR_W  = 8,
    parameter int          DW      = 32,
    parameter logic [31:0] VERSION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [NUM_CH-1:0] irq
);

    logic                      wr_en, rd_en, all_eoi;
    logic [NUM_CH-1:0]         wr_load, wr_ctrl, eoi_rd, raw_v;
    logic [NUM_CH-1:0][DW-1:0] load_v, count_v;
    tmr_ctrl_t [NUM_CH-1:0]    ctrl_v;

    assign wr_en   = psel && penable && pwrite;
    assign rd_en   = psel && penable && !pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    tmr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .paddr(paddr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_load(wr_load), .wr_ctrl(wr_ctrl), .eoi_rd(eoi_rd),
        .all_eoi(all_eoi)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst(rst),
            .wr_load(wr_load[i]), .wr_ctrl(wr_ctrl[i]), .wdata(pwdata),
            .eoi_clr(eoi_rd[i] | all_eoi),
            .load_o(load_v[i]), .count_o(count_v[i]), .ctrl_o(ctrl_v[i]),
            .raw_o(raw_v[i]), .irq_o(irq[i])
        );
    end

    tmr_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW), .VERSION(VERSION)) u_rd (
        .paddr(paddr), .load_v(load_v), .count_v(count_v), .ctrl_v(ctrl_v),
        .raw_v(raw_v), .pend_v(irq), .rdata(prdata)
    );

endmodule

// File: tb/test_apb_dcount_timer.sv
`timescale 1ns/1ps
module test_apb_dcount_timer;

    localparam logic [31:0] VER = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    apb_dcount_timer #(.NUM_CH(4), .ADDR_W(8), .DW(32), .VERSION(VER)) i_apb_dcount_timer (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .irq(irq)
    );

    // kind: 0 plain countdown (R3/R4), 1 free wrap (R5), 2 periodic (R6)
    typedef struct packed {
        logic [1:0]  ch;
        logic [2:0]  ctl;
        logic [31:0] load;
        logic [7:0]  gap;
        logic [31:0] exp;
        logic [1:0]  kind;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd1, 32'd100, 8'd0,  32'd99,        2'd0},
        '{2'd1, 3'd5, 32'd100, 8'd9,  32'd90,        2'd0},
        '{2'd2, 3'd1, 32'd3,   8'd5,  32'hFFFF_FFFD, 2'd1},
        '{2'd3, 3'd3, 32'd3,   8'd5,  32'd1,         2'd2},
        '{2'd0, 3'd3, 32'd0,   8'd4,  32'd0,         2'd2},
        '{2'd1, 3'd1, 32'd0,   8'd2,  32'hFFFF_FFFD, 2'd1},
        '{2'd2, 3'd7, 32'd10,  8'd20, 32'd0,         2'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk) penable = 1'b1;
        @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk) penable = 1'b1;
        #1 d = prdata;
        @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        case (k)
            2'd0:    return "R3 R4 countdown";
            2'd1:    return "R5 free wrap";
            default: return "R6 periodic reload";
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        apb_rd(8'h00, d); chk("R1 reload", d, 0);
        apb_rd(8'h04, d); chk("R1 count", d, 0);
        apb_rd(8'h08, d); chk("R1 ctrl", d, 0);
        apb_rd(8'hA8, d); chk("R1 raw", d, 0);
        apb_rd(8'hA0, d); chk("R1 masked", d, 0);
        chk("R1 irq", 32'(irq), 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            b = 8'(VEC[v].ch * 8'h14);
            apb_wr(b + 8'h08, 0);
            apb_wr(b + 8'h00, VEC[v].load);
            apb_wr(b + 8'h08, 32'(VEC[v].ctl));
            repeat (int'(VEC[v].gap)) @(negedge clk);
            apb_rd(b + 8'h04, d);
            chk(kind_tag(VEC[v].kind), d, VEC[v].exp);
        end

        // quiesce, R11 global clear
        for (int c = 0; c < 4; c++) apb_wr(8'(c * 8'h14) + 8'h08, 0);
        apb_rd(8'hA4, d); chk("R11 eoi read data", d, 0);
        apb_rd(8'hA8, d); chk("R11 raw cleared", d, 0);
        chk("R11 irq low", 32'(irq), 0);

        // R2 map and read-back
        apb_wr(8'h14, 32'h0000_ABCD);
        apb_rd(8'h14, d); chk("R2 reload readback ch1", d, 32'h0000_ABCD);
        apb_wr(8'h1C, 32'hFFFF_FFFE);
        apb_rd(8'h1C, d); chk("R2 ctrl readback ch1", d, 32'h6);

        // R7 reload write while enabled, R4 hold while disabled
        apb_wr(8'h00, 32'd1000);
        apb_wr(8'h08, 32'd1);
        apb_wr(8'h00, 32'd5);
        apb_rd(8'h04, d); chk("R7 running count untouched", d, 32'd997);
        apb_rd(8'h00, d); chk("R7 new reload stored", d, 32'd5);
        apb_wr(8'h08, 0);
        apb_rd(8'h04, a); chk("R4 count at disable", a, 32'd992);
        repeat (5) @(negedge clk);
        apb_rd(8'h04, d); chk("R4 hold while disabled", d, 32'd992);

        // R8 / R9 masking on ch2
        apb_wr(8'h28, 32'd2);
        apb_wr(8'h30, 32'd7);
        repeat (6) @(negedge clk);
        chk("R9 masked irq low", 32'(irq[2]), 0);
        apb_rd(8'hA8, d); chk("R8 raw set under mask", d & 32'h4, 32'h4);
        apb_rd(8'hA0, d); chk("R9 masked status clear", d & 32'h4, 0);
        apb_rd(8'h38, d); chk("R9 channel status masked", d, 0);
        apb_wr(8'h30, 32'd3);
        chk("R9 irq after unmask", 32'(irq[2]), 1);
        apb_rd(8'h38, d); chk("R9 channel status", d, 1);
        apb_rd(8'hA0, d); chk("R9 combined masked", d & 32'h4, 32'h4);

        // R13 disable keeps pending
        apb_wr(8'h30, 0);
        chk("R13 pending after disable", 32'(irq[2]), 1);

        // R10 per-channel clear with ch3 also pending
        apb_wr(8'h3C, 32'd2);
        apb_wr(8'h44, 32'd1);
        repeat (6) @(negedge clk);
        apb_wr(8'h44, 0);
        apb_rd(8'hA8, d); chk("R10 both pending", d, 32'hC);
        apb_rd(8'h34, d); chk("R10 eoi read data", d, 0);
        chk("R10 only ch2 cleared", 32'(irq), 32'h8);
        apb_rd(8'hA8, d); chk("R10 raw after ch2 clear", d, 32'h8);
        apb_rd(8'h30, d); chk("R10 ctrl untouched", d, 0);

        // R11 shared clear
        apb_rd(8'hA4, d); chk("R11 eoi read data 2", d, 0);
        chk("R11 irq all low", 32'(irq), 0);
        apb_rd(8'hA8, d); chk("R11 raw all clear", d, 0);

        // R12 version, unmapped, handshake
        apb_rd(8'hAC, d); chk("R12 version", d, VER);
        apb_rd(8'hB0, d); chk("R12 unmapped high", d, 0);
        apb_rd(8'h50, d); chk("R12 unmapped past channels", d, 0);
        apb_rd(8'h02, d); chk("R12 unaligned", d, 0);
        chk("R12 pready", 32'(pready), 1);
        chk("R12 pslverr", 32'(pslverr), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule